// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Register Lock

This block is a watchdog peripheral reached over an APB slave port. A down-counter, advanced by a separate count-enable tick, measures the time between software check-ins. When the counter runs out the first time, the block raises a warning flag and can drive an interrupt. It then reloads and keeps counting. If software has not cleared the warning by the next expiry, the block latches a reset request and stops counting. Software services the watchdog by writing the clear register, and it moves the deadline by writing a new reload value.

A key register guards every other register against stray writes. A test mode lets software drive both outputs directly. Read-only identification words sit at the top of the 4 KiB window. The parameter `ALT_VARIANT` selects a second flavour. In that flavour, control writes are refused once the interrupt enable is set, and the two test registers are not decoded. APB transfers always complete with no wait states and no error response.

The counter sequencer has four states:
- `S_COUNT`: running, warning clear.
- `S_WARN`: running, warning set.
- `S_HALT_WARN`: stopped, warning set.
- `S_HALT_CLR`: stopped, warning cleared.

Its transitions are:
- expire-one: `S_COUNT` to `S_WARN`.
- expire-two: `S_WARN` to `S_HALT_WARN`, which also latches the reset.
- service: `S_WARN` to `S_COUNT`, and `S_HALT_WARN` to `S_HALT_CLR`, on a clear write.
- restart: `S_HALT_WARN` to `S_WARN`, and `S_HALT_CLR` to `S_COUNT`, on a reload write.

Top module: `wdg_apb_top`

## Requirements
- R1: After reset, reads return 0xFFFFFFFF at offset 0x000 (reload) and at 0x004 (current count). Reads return 0 at 0x008 (control), 0x010 (raw flag), 0x014 (gated flag), 0xC00 (lock) and 0xF00 (test control). `irq_o` and `rst_req_o` are low, and the counter is running.
- R2: While running, the count at 0x004 drops by one in each cycle where `tick_i` is high, and holds in cycles where `tick_i` is low.
- R3: A write to 0x000 stores the reload value and puts the same value into the counter at once. A stopped counter starts running again, and the warning and latched reset are left as they were.
- R4: A tick with the count at 1 is an expiry and takes the count to 0. If the warning was clear, the expiry sets raw flag bit 0 at 0x010 and counting continues. A tick with the count at 0 reloads the counter from the reload value.
- R5: An expiry while the warning is set latches the reset. The counter then stops at 0 and ignores ticks. The latched reset is cleared only by `presetn`.
- R6: Any write to 0x00C clears the warning and reloads the counter from the reload value. The latched reset stays as it is, and a stopped counter stays stopped.
- R7: Control bit 0 is the interrupt enable and bit 1 is the reset enable; all other control bits read 0. `irq_o` is the warning AND bit 0, and 0x014 bit 0 returns the same value. `rst_req_o` is the latched reset AND bit 1.
- R8: Writing 0x1ACCE551 to 0xC00 unlocks the block, and writing any other value locks it. 0xC00 reads 1 while locked. While locked, writes to every other offset have no effect.
- R9: While 0xF00 bit 0 is 1, `irq_o` follows bit 1 of 0xF04 and `rst_req_o` follows bit 0 of 0xF04.
- R10: The twelve words at 0xFD0 to 0xFFC are read-only identification bytes. 0xFF0, 0xFF4, 0xFF8 and 0xFFC read 0x0D, 0xF0, 0x05 and 0xB1. 0xFE0 reads 0x24, or 0x05 when `ALT_VARIANT` is 1.
- R11: Writes to read-only or unmapped offsets have no effect. Reads of 0x00C, 0xF04 and unmapped offsets return 0.
- R12: With `ALT_VARIANT` = 1, control writes are ignored once control bit 0 is 1. 0xF00 and 0xF04 are then unmapped, so they read 0 and have no effect on the outputs.
- R13: A register write in the same cycle as a tick takes priority, and that tick is dropped. `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| tick_i | input | 1 | Count-enable pulse |
| irq_o | output | 1 | Warning interrupt |
| rst_req_o | output | 1 | Reset request |

## Verification
The bench drives the counter through both expiries and checks the count across the reload tick. An off-by-one in expiry detection would shift when the flag rises, and a missing reload would leave the count stuck at zero. It services the watchdog while the counter is stopped, to show that the latched reset survives a clear and that only a reload write restarts counting. Two faults would show up there: a design that clears the reset on service, or one that resumes counting on a clear. A write landing on the same cycle as a tick must leave the written value unchanged, and a design that let the tick through would read one less. Finally, the bench checks the lock, the test override and the variant's sticky enable. A lock that does not block writes, or an override that does not reach the outputs, shows up at once as a wrong read or a wrong output level.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        S_COUNT     = 2'd0,
        S_WARN      = 2'd1,
        S_HALT_WARN = 2'd2,
        S_HALT_CLR  = 2'd3
    } wdg_state_e;

    localparam logic [11:0] OFS_LOAD  = 12'h000;
    localparam logic [11:0] OFS_VALUE = 12'h004;
    localparam logic [11:0] OFS_CTRL  = 12'h008;
    localparam logic [11:0] OFS_ICLR  = 12'h00C;
    localparam logic [11:0] OFS_RAW   = 12'h010;
    localparam logic [11:0] OFS_MSK   = 12'h014;
    localparam logic [11:0] OFS_LOCK  = 12'hC00;
    localparam logic [11:0] OFS_TCTL  = 12'hF00;
    localparam logic [11:0] OFS_TOUT  = 12'hF04;
    localparam logic [9:0]  ID_WORD0  = 10'h3F4;
    localparam int          ID_COUNT  = 12;

    localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

    // identification byte for word index 0..11 counted from the first ID word
    function automatic logic [7:0] id_byte(input logic [3:0] idx, input bit alt);
        logic [7:0] b;
        case (idx)
            4'd0:    b = alt ? 8'h00 : 8'h04;
            4'd4:    b = alt ? 8'h05 : 8'h24;
            4'd5:    b = alt ? 8'h18 : 8'hB8;
            4'd6:    b = alt ? 8'h18 : 8'h1B;
            4'd7:    b = alt ? 8'h01 : 8'h00;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_wr_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             clr_wr_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             raw_int_o,
    output logic             rst_lat_o
);

    wdg_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             rst_lat_q, rst_set;
    logic             running;

    // state register and counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_COUNT;
            cnt_q     <= '1;
            rst_lat_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            rst_lat_q <= rst_lat_q | rst_set;
        end
    end

    // outputs decoded from state
    always_comb begin
        running   = 1'b0;
        raw_int_o = 1'b0;
        unique case (state_q)
            S_COUNT:     running = 1'b1;
            S_WARN:      begin running = 1'b1; raw_int_o = 1'b1; end
            S_HALT_WARN: raw_int_o = 1'b1;
            S_HALT_CLR:  running = 1'b0;
        endcase
        count_o   = cnt_q;
        rst_lat_o = rst_lat_q;
    end

    // next state: a bus write outranks a tick in the same cycle
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        rst_set = 1'b0;
        if (load_wr_i) begin
            cnt_d = load_val_i;
            unique case (state_q)
                S_HALT_WARN:     state_d = S_WARN;
                S_HALT_CLR:      state_d = S_COUNT;
                S_COUNT, S_WARN: state_d = state_q;
            endcase
        end else if (clr_wr_i) begin
            cnt_d = reload_i;
            unique case (state_q)
                S_WARN:              state_d = S_COUNT;
                S_HALT_WARN:         state_d = S_HALT_CLR;
                S_COUNT, S_HALT_CLR: state_d = state_q;
            endcase
        end else if (tick_i && running) begin
            if (cnt_q == CNT_W'(1)) begin
                cnt_d   = '0;
                rst_set = (state_q == S_WARN);
                state_d = (state_q == S_WARN) ? S_HALT_WARN : S_WARN;
            end else if (cnt_q == '0) begin
                cnt_d = reload_i;
            end else begin
                cnt_d = cnt_q - CNT_W'(1);
            end
        end
    end

    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !load_wr_i && !clr_wr_i) |=> $stable(cnt_q));

    // R5
    rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_lat_q |=> rst_lat_q);

    // R6
    raw_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(raw_int_o) |-> $past(clr_wr_i));

    // R4
    first_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COUNT && tick_i && cnt_q == CNT_W'(1) && !load_wr_i && !clr_wr_i)
        |=> (raw_int_o && cnt_q == '0));

endmodule

// File: rtl/wdg_regfile.sv
module wdg_regfile
    import wdg_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter bit ALT_VARIANT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [11:0]      paddr,
    input  logic [31:0]      pwdata,
    output logic [31:0]      prdata,
    input  logic [CNT_W-1:0] count_i,
    input  logic             raw_int_i,
    output logic [CNT_W-1:0] reload_o,
    output logic             load_wr_o,
    output logic             clr_wr_o,
    output logic             ie_o,
    output logic             re_o,
    output logic             tm_en_o,
    output logic             tm_irq_o,
    output logic             tm_rst_o
);

    localparam bit HAS_TEST = !ALT_VARIANT;

    logic             wr_acc, wr_ok, ctrl_open;
    logic             lock_q, ie_q, re_q;
    logic [CNT_W-1:0] load_q;
    logic [9:0]       word;
    logic [9:0]       id_ofs;

    assign wr_acc    = psel & penable & pwrite;
    assign wr_ok     = wr_acc & (~lock_q | (paddr == OFS_LOCK));
    assign ctrl_open = ~(ALT_VARIANT & ie_q);
    assign load_wr_o = wr_ok & (paddr == OFS_LOAD);
    assign clr_wr_o  = wr_ok & (paddr == OFS_ICLR);
    assign word      = paddr[11:2];
    assign id_ofs    = word - ID_WORD0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            ie_q   <= 1'b0;
            re_q   <= 1'b0;
            load_q <= '1;
        end else if (wr_ok) begin
            case (paddr)
                OFS_LOAD: load_q <= pwdata[CNT_W-1:0];
                OFS_CTRL: if (ctrl_open) {re_q, ie_q} <= pwdata[1:0];
                OFS_LOCK: lock_q <= (pwdata != UNLOCK_KEY);
                default:  ;
            endcase
        end
    end

    generate
        if (HAS_TEST) begin : g_test
            logic tm_en_q, tm_irq_q, tm_rst_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tm_en_q  <= 1'b0;
                    tm_irq_q <= 1'b0;
                    tm_rst_q <= 1'b0;
                end else if (wr_ok && paddr == OFS_TCTL) begin
                    tm_en_q <= pwdata[0];
                end else if (wr_ok && paddr == OFS_TOUT) begin
                    {tm_irq_q, tm_rst_q} <= pwdata[1:0];
                end
            end
            assign tm_en_o  = tm_en_q;
            assign tm_irq_o = tm_irq_q;
            assign tm_rst_o = tm_rst_q;
        end else begin : g_no_test
            assign tm_en_o  = 1'b0;
            assign tm_irq_o = 1'b0;
            assign tm_rst_o = 1'b0;

            // R12
            sticky_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ie_q |=> ie_q);
        end
    endgenerate

    // read mux
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (paddr)
                OFS_LOAD:  prdata = 32'(load_q);
                OFS_VALUE: prdata = 32'(count_i);
                OFS_CTRL:  prdata = {30'b0, re_q, ie_q};
                OFS_RAW:   prdata = {31'b0, raw_int_i};
                OFS_MSK:   prdata = {31'b0, raw_int_i & ie_q};
                OFS_LOCK:  prdata = {31'b0, lock_q};
                OFS_TCTL:  prdata = {31'b0, tm_en_o};
                default: begin
                    if (paddr[1:0] == 2'b00 && word >= ID_WORD0 &&
                        id_ofs < 10'(ID_COUNT))
                        prdata = {24'b0, id_byte(id_ofs[3:0], ALT_VARIANT)};
                end
            endcase
        end
    end

    assign reload_o = load_q;
    assign ie_o     = ie_q;
    assign re_o     = re_q;

    // R8
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && wr_acc && paddr != OFS_LOCK)
        |=> ($stable(ie_q) && $stable(re_q) && $stable(load_q)));

endmodule

// File: rtl/wdg_apb_top.sv
module wdg_apb_top
    import wdg_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter bit ALT_VARIANT = 1'b0
) (
    input  logic        pclk,
    input  logic        presetn,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [11:0] paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    output logic        pready,
    output logic        pslverr,
    input  logic        tick_i,
    output logic        irq_o,
    output logic        rst_req_o
);

    logic [CNT_W-1:0] reload, count;
    logic             load_wr, clr_wr, ie, re;
    logic             tm_en, tm_irq, tm_rst;
    logic             raw_int, rst_lat;

    wdg_regfile #(
        .CNT_W      (CNT_W),
        .ALT_VARIANT(ALT_VARIANT)
    ) u_regs (
        .clk      (pclk),
        .rst_n    (presetn),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .prdata   (prdata),
        .count_i  (count),
        .raw_int_i(raw_int),
        .reload_o (reload),
        .load_wr_o(load_wr),
        .clr_wr_o (clr_wr),
        .ie_o     (ie),
        .re_o     (re),
        .tm_en_o  (tm_en),
        .tm_irq_o (tm_irq),
        .tm_rst_o (tm_rst)
    );

    wdg_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk       (pclk),
        .rst_n     (presetn),
        .tick_i    (tick_i),
        .load_wr_i (load_wr),
        .load_val_i(pwdata[CNT_W-1:0]),
        .clr_wr_i  (clr_wr),
        .reload_i  (reload),
        .count_o   (count),
        .raw_int_o (raw_int),
        .rst_lat_o (rst_lat)
    );

    // output selection: test override or gated status
    always_comb begin
        if (tm_en) begin
            irq_o     = tm_irq;
            rst_req_o = tm_rst;
        end else begin
            irq_o     = raw_int & ie;
            rst_req_o = rst_lat & re;
        end
    end

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

endmodule

// File: tb/wdg_apb_top_tb_top.sv
module wdg_apb_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h000, 32'h0, 32'hFFFFFFFF, 8'd1},  // R1
        '{1'b0, 12'h004, 32'h0, 32'hFFFFFFFF, 8'd1},  // R1
        '{1'b0, 12'h008, 32'h0, 32'h0, 8'd1},         // R1
        '{1'b0, 12'h010, 32'h0, 32'h0, 8'd1},         // R1
        '{1'b0, 12'h014, 32'h0, 32'h0, 8'd1},         // R1
        '{1'b0, 12'hC00, 32'h0, 32'h0, 8'd1},         // R1
        '{1'b0, 12'hF00, 32'h0, 32'h0, 8'd1},         // R1
        '{1'b0, 12'hFE0, 32'h0, 32'h24, 8'd10},       // R10
        '{1'b0, 12'hFF0, 32'h0, 32'h0D, 8'd10},       // R10
        '{1'b0, 12'hFF4, 32'h0, 32'hF0, 8'd10},       // R10
        '{1'b0, 12'hFF8, 32'h0, 32'h05, 8'd10},       // R10
        '{1'b0, 12'hFFC, 32'h0, 32'hB1, 8'd10},       // R10
        '{1'b0, 12'h00C, 32'h0, 32'h0, 8'd11},        // R11
        '{1'b0, 12'hF04, 32'h0, 32'h0, 8'd11},        // R11
        '{1'b0, 12'h800, 32'h0, 32'h0, 8'd11},        // R11
        '{1'b1, 12'h004, 32'h1234, 32'h0, 8'd11},     // R11
        '{1'b0, 12'h004, 32'h0, 32'hFFFFFFFF, 8'd11}, // R11
        '{1'b1, 12'hFE0, 32'h0, 32'h0, 8'd11},        // R11
        '{1'b0, 12'hFE0, 32'h0, 32'h24, 8'd11},       // R11
        '{1'b1, 12'h008, 32'hFFFFFFFF, 32'h0, 8'd7},  // R7
        '{1'b0, 12'h008, 32'h0, 32'h3, 8'd7},         // R7
        '{1'b1, 12'h008, 32'h0, 32'h0, 8'd7},         // R7
        '{1'b1, 12'hC00, 32'h0, 32'h0, 8'd8},         // R8
        '{1'b0, 12'hC00, 32'h0, 32'h1, 8'd8},         // R8
        '{1'b1, 12'h008, 32'h3, 32'h0, 8'd8},         // R8
        '{1'b0, 12'h008, 32'h0, 32'h0, 8'd8},         // R8
        '{1'b1, 12'hC00, 32'h1ACCE551, 32'h0, 8'd8},  // R8
        '{1'b0, 12'hC00, 32'h0, 32'h0, 8'd8}          // R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_a = 1'b0, sel_b = 1'b0;
    logic        penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic        tick = 1'b0;
    logic [31:0] prdata_a, prdata_b;
    logic        pready_a, pready_b, pslverr_a, pslverr_b;
    logic        irq_a, irq_b, rst_a, rst_b;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdg_apb_top #(.ALT_VARIANT(1'b0)) dut_i (
        .pclk(clk), .presetn(rst_n), .psel(sel_a), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_a),
        .pready(pready_a), .pslverr(pslverr_a), .tick_i(tick),
        .irq_o(irq_a), .rst_req_o(rst_a)
    );

    wdg_apb_top #(.ALT_VARIANT(1'b1)) dut_v_i (
        .pclk(clk), .presetn(rst_n), .psel(sel_b), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_b),
        .pready(pready_b), .pslverr(pslverr_b), .tick_i(tick),
        .irq_o(irq_b), .rst_req_o(rst_b)
    );

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp,
                         input string what);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, got, exp);
        end
    endtask

    task automatic apb_wr(input bit to_b, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        sel_a = !to_b; sel_b = to_b; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        sel_a = 1'b0; sel_b = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input bit to_b, input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        sel_a = !to_b; sel_b = to_b; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = to_b ? prdata_b : prdata_a;
        @(negedge clk);
        sel_a = 1'b0; sel_b = 1'b0; penable = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic rd_chk(input bit to_b, input logic [11:0] a, input logic [31:0] exp,
                          input int req, input string what);
        logic [31:0] d;
        apb_rd(to_b, a, d);
        check(req, d, exp, what);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 outputs after reset
        check(1, {31'b0, irq_a}, 32'h0, "irq after reset");
        check(1, {31'b0, rst_a}, 32'h0, "rst_req after reset");
        // R13 bus response constants
        check(13, {30'b0, pready_a, pslverr_a}, 32'h2, "pready/pslverr");

        // vector table, no ticks
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                apb_wr(1'b0, VECS[i].addr, VECS[i].data);
            end else begin
                logic [31:0] d;
                apb_rd(1'b0, VECS[i].addr, d);
                check(int'(VECS[i].req), d, VECS[i].exp, "table read");
            end
        end

        // R3 load write sets counter immediately
        apb_wr(1'b0, 12'h000, 32'd5);
        rd_chk(1'b0, 12'h004, 32'd5, 3, "count after load");
        // R2 decrement per tick, hold without tick
        ticks(3);
        rd_chk(1'b0, 12'h004, 32'd2, 2, "count after 3 ticks");
        repeat (4) @(negedge clk);
        rd_chk(1'b0, 12'h004, 32'd2, 2, "count holds without tick");
        // R4 first expiry
        ticks(2);
        rd_chk(1'b0, 12'h004, 32'd0, 4, "count at expiry");
        rd_chk(1'b0, 12'h010, 32'd1, 4, "raw flag after first expiry");
        // R7 gating by interrupt enable
        check(7, {31'b0, irq_a}, 32'h0, "irq gated off");
        rd_chk(1'b0, 12'h014, 32'd0, 7, "masked status gated off");
        apb_wr(1'b0, 12'h008, 32'd1);
        check(7, {31'b0, irq_a}, 32'h1, "irq enabled");
        rd_chk(1'b0, 12'h014, 32'd1, 7, "masked status enabled");
        // R4 reload tick from zero
        ticks(1);
        rd_chk(1'b0, 12'h004, 32'd5, 4, "reload after zero");
        // R6 clear
        ticks(2);
        apb_wr(1'b0, 12'h00C, 32'd0);
        rd_chk(1'b0, 12'h010, 32'd0, 6, "raw after clear");
        rd_chk(1'b0, 12'h004, 32'd5, 6, "count reloaded by clear");
        check(6, {31'b0, irq_a}, 32'h0, "irq after clear");

        // R5 second expiry
        apb_wr(1'b0, 12'h008, 32'd3);
        ticks(5);
        check(4, {31'b0, irq_a}, 32'h1, "irq after first expiry");
        check(5, {31'b0, rst_a}, 32'h0, "no reset after first expiry");
        ticks(6);
        check(5, {31'b0, rst_a}, 32'h1, "reset after second expiry");
        ticks(3);
        rd_chk(1'b0, 12'h004, 32'd0, 5, "count stopped");
        // R6 clear while stopped keeps reset, stays stopped
        apb_wr(1'b0, 12'h00C, 32'd0);
        check(6, {31'b0, rst_a}, 32'h1, "reset kept after clear");
        check(6, {31'b0, irq_a}, 32'h0, "irq after clear when stopped");
        ticks(2);
        rd_chk(1'b0, 12'h004, 32'd5, 6, "stays stopped after clear");
        // R3 load restarts
        apb_wr(1'b0, 12'h000, 32'd3);
        ticks(1);
        rd_chk(1'b0, 12'h004, 32'd2, 3, "restart after load");
        check(3, {31'b0, rst_a}, 32'h1, "reset kept after load");
        apb_wr(1'b0, 12'h008, 32'd1);
        check(7, {31'b0, rst_a}, 32'h0, "reset gated by enable");

        // R9 test override
        apb_wr(1'b0, 12'hF04, 32'd2);
        apb_wr(1'b0, 12'hF00, 32'd1);
        check(9, {30'b0, irq_a, rst_a}, 32'h2, "override irq only");
        apb_wr(1'b0, 12'hF04, 32'd1);
        check(9, {30'b0, irq_a, rst_a}, 32'h1, "override rst only");
        rd_chk(1'b0, 12'hF00, 32'd1, 9, "test control readback");
        apb_wr(1'b0, 12'hF00, 32'd0);
        check(9, {30'b0, irq_a, rst_a}, 32'h0, "override off");

        // R8 lock blocks load, control and clear
        apb_wr(1'b0, 12'hC00, 32'hDEAD);
        apb_wr(1'b0, 12'h000, 32'd7);
        apb_wr(1'b0, 12'h008, 32'd0);
        rd_chk(1'b0, 12'h004, 32'd2, 8, "count unchanged while locked");
        rd_chk(1'b0, 12'h008, 32'd1, 8, "control unchanged while locked");
        apb_wr(1'b0, 12'hC00, 32'h1ACCE551);
        rd_chk(1'b0, 12'h000, 32'd3, 8, "reload unchanged after unlock");

        // R13 write beats tick in the same cycle
        @(negedge clk);
        sel_a = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 12'h000; pwdata = 32'd9;
        @(negedge clk);
        penable = 1'b1; tick = 1'b1;
        @(negedge clk);
        sel_a = 1'b0; penable = 1'b0; pwrite = 1'b0; tick = 1'b0;
        rd_chk(1'b0, 12'h004, 32'd9, 13, "write wins over tick");
        ticks(1);
        rd_chk(1'b0, 12'h004, 32'd8, 13, "tick after collision");

        // R12 variant: sticky interrupt enable, no test registers
        apb_wr(1'b1, 12'h008, 32'd2);
        rd_chk(1'b1, 12'h008, 32'd2, 12, "variant control writable");
        apb_wr(1'b1, 12'h008, 32'd1);
        apb_wr(1'b1, 12'h008, 32'd0);
        rd_chk(1'b1, 12'h008, 32'd1, 12, "variant control sticky");
        apb_wr(1'b1, 12'hF04, 32'd3);
        apb_wr(1'b1, 12'hF00, 32'd1);
        rd_chk(1'b1, 12'hF00, 32'd0, 12, "variant test control unmapped");
        check(12, {30'b0, irq_b, rst_b}, 32'h0, "variant outputs not overridden");
        // R10 variant identification
        rd_chk(1'b1, 12'hFE0, 32'h05, 10, "variant id word");
        rd_chk(1'b1, 12'hFFC, 32'hB1, 10, "variant last id word");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule